// File: doc/BRIEF.md
# LPC Memory Read Target

This block is the peripheral end of a Low Pin Count bus that answers host memory reads. It watches the 4-bit LAD bus together with the active-low frame strobe. It recognises the start nibble and checks the cycle-type nibble. It assembles a 32-bit address that arrives high nibble first and tests it against a configurable decode window.

When the address hits, the block issues a single-clock request on a synchronous memory port and latches the byte that comes back one clock later. It then takes the bus after the two turnaround clocks, drives a ready sync nibble and returns the byte low nibble first. It finishes by driving all ones for one clock and releasing LAD.

LAD is modelled as a separate input nibble, output nibble and output enable, so the pad can be built outside the block. Clock numbers below count from 1 at the clock that carries the start nibble.

Top module: `lpc_rd_target`

## Requirements
- R1: A synchronous active-high reset, applied at any time, leaves lad_oe and mem_req low from the next clock until a new cycle starts.
- R2: A cycle starts only on a clock where lframe_n is low and lad_in is 4'b0000; any other nibble with lframe_n low starts nothing.
- R3: The clock after the start carries the cycle type. A value whose bits 3:1 are 3'b010 is a memory read, whatever bit 0 holds. Any other value returns the block to idle with no request and no drive.
- R4: Clocks 3 to 10 carry the address, A31..A28 first and A3..A0 last. In clock 11 mem_req is high for exactly one clock, and mem_addr presents the low MEM_AW address bits.
- R5: An address for which (addr & WIN_MASK) != (WIN_BASE & WIN_MASK) produces no request and no drive, and the block returns to idle.
- R6: lad_oe is low in clocks 11 and 12, high in clocks 13 to 16, and low again in clock 17.
- R7: In clock 13 the block drives the sync nibble 4'b0000.
- R8: mem_rdata is taken in clock 12, the clock after the request. In clock 14 lad_out carries data bits 3:0, and in clock 15 it carries bits 7:4.
- R9: In clock 16 lad_out is 4'b1111. A new start nibble in clock 18 begins the next cycle with no idle gap.
- R10: lframe_n low in any clock aborts the cycle in progress, so lad_oe and mem_req are low in the next clock. If that clock also carries 4'b0000, it is taken as a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| lframe_n | input | 1 | Frame strobe from host, active low |
| lad_in | input | 4 | Nibble sampled from LAD |
| lad_oe | output | 1 | LAD output enable |
| lad_out | output | 4 | Nibble driven on LAD when enabled |
| mem_req | output | 1 | One-clock read request to memory |
| mem_addr | output | MEM_AW | Read address, valid with mem_req |
| mem_rdata | input | 8 | Read byte, valid the clock after mem_req |

## Verification
The assertions assume the memory answers every request with a valid byte exactly one clock later. They also assume the host never drives a start while reset is held. The bench memory model registers its reply on the request edge and puts random bytes on mem_rdata in every other clock, so a latch taken in the wrong clock shows up as wrong data. Host stimulus mixes random cycle types and addresses, both inside and outside the window. It adds directed aborts at several depths, a false start, reset in mid-transfer and back-to-back reads. Every lframe_n pulse it produces follows the framing rules.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_TAR0,
        ST_TAR1,
        ST_SYNC,
        ST_DLO,
        ST_DHI,
        ST_TRD0,
        ST_TRD1
    } lpc_st_e;

    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_SYNC  = 4'h0;
    localparam logic [3:0] NIB_ONES  = 4'hF;
    localparam int         ADDR_W    = 32;
    localparam int         NIBS      = ADDR_W / 4;

    // memory read: bits 3:2 = 01, bit 1 = 0, bit 0 don't care
    function automatic logic is_mem_read(input logic [3:0] nib);
        return nib[3:1] == 3'b010;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input logic [ADDR_W-1:0] mask);
        return (a & mask) == (base & mask);
    endfunction

    function automatic logic drives_bus(input lpc_st_e st);
        return (st == ST_SYNC) || (st == ST_DLO) || (st == ST_DHI) || (st == ST_TRD0);
    endfunction

endpackage

// File: rtl/lpc_rd_addr.sv
module lpc_rd_addr
    import lpc_rd_pkg::*;
#(
    parameter int MEM_AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [3:0]        lad_in,
    output logic [ADDR_W-1:0] addr_next,
    output logic [MEM_AW-1:0] mem_addr
);
    logic [ADDR_W-1:0] sr_q;

    assign addr_next = {sr_q[ADDR_W-5:0], lad_in};
    assign mem_addr  = sr_q[MEM_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= addr_next;
    end
endmodule

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
    import lpc_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lframe_n,
    input  logic [3:0] lad_in,
    input  logic       addr_ok,
    output lpc_st_e    state,
    output logic       shift_en
);
    localparam int CNT_W = $clog2(NIBS);

    lpc_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_nib;

    assign last_nib = cnt_q == CNT_W'(NIBS - 1);
    assign state    = st_q;
    assign shift_en = (st_q == ST_ADDR) && lframe_n;

    always_comb begin
        st_d = st_q;
        if (!lframe_n) begin
            st_d = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_CTYPE: st_d = is_mem_read(lad_in) ? ST_ADDR : ST_IDLE;
                ST_ADDR:  st_d = last_nib ? (addr_ok ? ST_TAR0 : ST_IDLE) : ST_ADDR;
                ST_TAR0:  st_d = ST_TAR1;
                ST_TAR1:  st_d = ST_SYNC;
                ST_SYNC:  st_d = ST_DLO;
                ST_DLO:   st_d = ST_DHI;
                ST_DHI:   st_d = ST_TRD0;
                ST_TRD0:  st_d = ST_TRD1;
                ST_TRD1:  st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= shift_en ? cnt_q + 1'b1 : '0;
        end
    end

    // R4: the turnaround is entered only after all eight address nibbles
    assert_addr_len_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TAR0) |-> ($past(st_q) == ST_ADDR && $past(cnt_q) == CNT_W'(NIBS - 1)));

    // R3: the address phase is entered only from a cycle-type clock carrying a memory read
    assert_ctype_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_ADDR) |-> ($past(st_q) == ST_CTYPE && $past(lad_in[3:1]) == 3'b010));
endmodule

// File: rtl/lpc_rd_drive.sv
module lpc_rd_drive
    import lpc_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpc_st_e    state,
    input  logic [7:0] mem_rdata,
    output logic       lad_oe,
    output logic [3:0] lad_out
);
    logic [7:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst)                    byte_q <= '0;
        else if (state == ST_TAR1)  byte_q <= mem_rdata;
    end

    assign lad_oe = drives_bus(state);

    always_comb begin
        unique case (state)
            ST_SYNC: lad_out = NIB_SYNC;
            ST_DLO:  lad_out = byte_q[3:0];
            ST_DHI:  lad_out = byte_q[7:4];
            default: lad_out = NIB_ONES;
        endcase
    end

    // R7: whenever the block takes the bus, the first nibble is sync
    assert_sync_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lad_oe) |-> (lad_out == NIB_SYNC));

    // R8: the high data nibble follows the low one with the bus still held
    assert_hi_after_lo_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DHI) |-> ($past(state) == ST_DLO && $past(lad_oe)));
endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
    import lpc_rd_pkg::*;
#(
    parameter int          MEM_AW   = 18,
    parameter logic [31:0] WIN_BASE = 32'hFFFC_0000,
    parameter logic [31:0] WIN_MASK = 32'hFFFC_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    output logic              lad_oe,
    output logic [3:0]        lad_out,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    lpc_st_e           state;
    logic              shift_en;
    logic [ADDR_W-1:0] addr_next;
    logic              addr_ok;

    assign addr_ok = in_window(addr_next, WIN_BASE, WIN_MASK);
    assign mem_req = (state == ST_TAR0);

    lpc_rd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lframe_n (lframe_n),
        .lad_in   (lad_in),
        .addr_ok  (addr_ok),
        .state    (state),
        .shift_en (shift_en)
    );

    lpc_rd_addr #(.MEM_AW(MEM_AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .lad_in    (lad_in),
        .addr_next (addr_next),
        .mem_addr  (mem_addr)
    );

    lpc_rd_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mem_rdata (mem_rdata),
        .lad_oe    (lad_oe),
        .lad_out   (lad_out)
    );

    // R1: reset silences the bus and the memory port on the next clock
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!lad_oe && !mem_req));

    // R4: the memory request is a single-clock pulse
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R6: the bus is taken two clocks after the request
    assert_take_after_req_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lad_oe) |-> $past(mem_req, 2));

    // R9: a transfer that is not interrupted releases the bus after driving all ones
    assert_release_ones_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(lad_oe) && $past(lframe_n) && !$past(rst)) |-> ($past(lad_out) == NIB_ONES));

    // R10: a frame strobe aborts drive and request on the following clock
    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |=> (!lad_oe && !mem_req));
endmodule

// File: tb/lpc_rd_target_tb_top.sv
`timescale 1ns/1ps
module lpc_rd_target_tb_top;
    localparam int          MEM_AW   = 18;
    localparam logic [31:0] WIN_BASE = 32'hFFFC_0000;
    localparam logic [31:0] WIN_MASK = 32'hFFFC_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lframe_n = 1'b1;
    logic [3:0]        lad_in = 4'hF;
    logic              lad_oe;
    logic [3:0]        lad_out;
    logic              mem_req;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        mem_rdata = 8'h00;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    lpc_rd_target #(.MEM_AW(MEM_AW), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) dut_i (
        .clk(clk), .rst(rst), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_oe(lad_oe), .lad_out(lad_out), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [MEM_AW-1:0] a);
        return a[7:0] ^ {2'b00, a[17:12]} ^ 8'h5A;
    endfunction

    // memory: reply one clock after the request, noise otherwise
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem_byte(mem_addr);
        else         mem_rdata <= 8'($urandom);
    end

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock: check outputs of this clock, then drive host inputs for it
    task automatic step(input logic lf, input logic [3:0] nib, input bit do_chk,
                        input logic exp_oe, input logic [3:0] exp_lad,
                        input logic exp_req, input logic [MEM_AW-1:0] exp_addr,
                        input string req);
        @(negedge clk);
        if (do_chk) begin
            check(req, "lad_oe", 32'(lad_oe), 32'(exp_oe));
            check(req, "mem_req", 32'(mem_req), 32'(exp_req));
            if (exp_oe)  check(req, "lad_out", 32'(lad_out), 32'(exp_lad));
            if (exp_req) check(req, "mem_addr", 32'(mem_addr), 32'(exp_addr));
        end
        lframe_n = lf;
        lad_in   = nib;
    endtask

    // drive clocks 1..nclk of a read cycle with predicted outputs
    task automatic read_cycle(input logic [3:0] start_nib, input logic [3:0] ctype,
                              input logic [31:0] addr, input int nclk, input bit skip_first,
                              input string req);
        bit ok;
        logic [7:0] d;
        ok = (start_nib == 4'h0) && (ctype[3:1] == 3'b010) &&
             ((addr & WIN_MASK) == (WIN_BASE & WIN_MASK));
        d  = mem_byte(addr[MEM_AW-1:0]);
        for (int k = 1; k <= nclk; k++) begin
            logic [3:0] nib;
            logic       e_oe;
            logic [3:0] e_lad;
            if (k == 1)       nib = start_nib;
            else if (k == 2)  nib = ctype;
            else if (k <= 10) nib = addr[31 - 4*(k-3) -: 4];
            else              nib = 4'hF;
            e_oe  = ok && (k >= 13) && (k <= 16);
            e_lad = (k == 13) ? 4'h0 : (k == 14) ? d[3:0] : (k == 15) ? d[7:4] : 4'hF;
            step((k == 1) ? 1'b0 : 1'b1, nib, !(skip_first && k == 1),
                 e_oe, e_lad, ok && (k == 11), addr[MEM_AW-1:0], req);
        end
    endtask

    task automatic idle_check(input int n, input string req);
        for (int i = 0; i < n; i++)
            step(1'b1, 4'hF, 1'b1, 1'b0, 4'hF, 1'b0, '0, req);
    endtask

    function automatic logic [31:0] in_addr();
        return WIN_BASE | ($urandom & ~WIN_MASK);
    endfunction

    initial begin
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "lad_oe in reset", 32'(lad_oe), 32'd0);
        check("R1", "mem_req in reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        idle_check(2, "R1");

        // R4 R6 R7 R8 R9: directed in-window read
        read_cycle(4'h0, 4'h4, 32'hFFFC_1234, 17, 0, "R8");
        // R3: bit 0 of cycle type ignored; back-to-back start in clock 18 (R9)
        read_cycle(4'h0, 4'h5, 32'hFFFF_FFFF, 17, 0, "R3");
        read_cycle(4'h0, 4'h4, 32'hFFFC_0000, 17, 0, "R9");
        // R3: write type and other types rejected
        read_cycle(4'h0, 4'h6, 32'hFFFC_0040, 17, 0, "R3");
        read_cycle(4'h0, 4'h0, 32'hFFFC_0040, 17, 0, "R3");
        // R5: outside the window
        read_cycle(4'h0, 4'h4, 32'hFFF8_0010, 17, 0, "R5");
        read_cycle(4'h0, 4'h4, 32'h0003_FFFF, 17, 0, "R5");
        // R2: a non-zero nibble with lframe_n low starts nothing
        read_cycle(4'h3, 4'h4, 32'hFFFC_0101, 17, 0, "R2");
        idle_check(1, "R2");

        // R10: abort mid-address, with restart on the same clock
        read_cycle(4'h0, 4'h4, 32'hFFFC_2222, 6, 0, "R10");
        read_cycle(4'h0, 4'h4, 32'hFFFC_3333, 17, 1, "R10");
        // R10: abort while driving data, non-start nibble
        read_cycle(4'h0, 4'h4, 32'hFFFC_4444, 14, 0, "R10");
        step(1'b0, 4'hF, 1'b0, 1'b0, 4'hF, 1'b0, '0, "R10");
        idle_check(3, "R10");
        // R10: abort during data with immediate restart
        read_cycle(4'h0, 4'h4, 32'hFFFC_5555, 15, 0, "R10");
        read_cycle(4'h0, 4'h4, 32'hFFFC_6666, 17, 1, "R10");

        // R1: reset in the middle of a data phase
        read_cycle(4'h0, 4'h4, 32'hFFFC_7777, 14, 0, "R1");
        @(negedge clk); lframe_n = 1'b1; lad_in = 4'hF; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", "lad_oe after reset", 32'(lad_oe), 32'd0);
        check("R1", "mem_req after reset", 32'(mem_req), 32'd0);
        idle_check(2, "R1");
        read_cycle(4'h0, 4'h4, 32'hFFFC_8888, 17, 0, "R1");

        // random mix
        for (int t = 0; t < 300; t++) begin
            logic [3:0]  ct;
            logic [31:0] a;
            ct = ($urandom_range(0, 3) == 0) ? 4'($urandom) : {3'b010, 1'($urandom)};
            a  = ($urandom_range(0, 3) == 0) ? $urandom : in_addr();
            read_cycle(4'h0, ct, a, 17, 0, "R4");
            if ($urandom_range(0, 1) == 0) idle_check($urandom_range(1, 3), "R9");
        end

        idle_check(2, "R9");
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule